// File: doc/BRIEF.md
# Three-Modulus Mixed-Radix Reverse Converter

This block turns a residue triple over the pairwise coprime moduli 2m−1, 2m and 2m+1 back into an ordinary binary integer. It is purely combinational. The residue for 2m is used directly as the lowest mixed-radix digit. A middle digit is taken from the difference between the 2m and 2m+1 residues. A top digit is then obtained with a single modular reduction over 2m−1, and the integer is rebuilt from the three digits. The two upper mixed-radix digits are also brought out, because they let later logic compare or scale values without waiting for the full binary result.

The modulus parameter `M` (written m in this brief) sets all widths. With the default m = 21 the moduli are 41, 42 and 43, and the dynamic range is 74046, which is just over 16 bits. The block expects residues that are already in range. Producing residues from a binary value, and flagging out-of-range residues, are left to neighbouring logic.

The internal path works as follows:
- The middle digit comes from x2 − x3. A wrap flag is raised when that difference is negative, and 2m+1 is then added back.
- The wrap flag also feeds the top-digit path at once. That path folds x3 − 2·x2 + x1 − 2·flag into one carry-save sum and reduces it once, by choosing among four corrected candidates.
- The reduced value is scaled by m modulo 2m−1. This uses a one-bit shift and a gated add.

Top module: `mrc_rns2bin`

## Requirements
- R1: For every residue triple with x1 < 2m−1, x2 < 2m and x3 < 2m+1, `value_o` equals the unique X in [0, 2m(4m²−1)) with X mod (2m−1) = x1, X mod 2m = x2 and X mod (2m+1) = x3.
- R2: `digit_p_o` equals floor(X / 2m) mod (2m+1), and it is always below 2m+1.
- R3: `digit_q_o` equals floor(X / (2m·(2m+1))), and it is always below 2m−1.
- R4: When x2 ≥ x3, `digit_p_o` equals x2 − x3. When x2 < x3, it equals x2 − x3 + 2m + 1.
- R5: For equal residues x1 = x2 = x3 = r with r < 2m−1, `value_o` is r and both digits are 0.
- R6: The triple (2m−2, 2m−1, 2m) yields `value_o` = 2m(4m²−1) − 1 and `digit_q_o` = 2m−2.
- R7: The all-zero triple yields zero on all three outputs.
- R8: The top digit is correct at both extremes of the unreduced sum. The low extreme is x1 = x3 = 0 with any x2. The high extreme is x1 = 2m−2, x3 = 2m and x2 < x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| res_m1_i | input | K = clog2(2m+2) | Residue modulo 2m−1 |
| res_m2_i | input | K | Residue modulo 2m |
| res_m3_i | input | K | Residue modulo 2m+1 |
| value_o | output | 3K | Reconstructed binary integer |
| digit_p_o | output | K | Middle mixed-radix digit (radix 2m+1) |
| digit_q_o | output | K | Top mixed-radix digit (radix 2m−1) |

## Verification
The bench walks every integer in the dynamic range, one per cycle, so that each residue triple is applied once. The outputs are compared with the integer itself and with its mixed-radix digits found by division. This sweep shows whether the wrap flag and the four correction candidates are chosen correctly. Directed passes then apply the two families of triples that push the unreduced sum to its most negative and most positive values, which separates a wrong outer candidate from a wrong inner one. The equal-residue diagonal and the top of the range are also applied as directed cases; they show up offset mistakes in the digit weights of the rebuild.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    // Candidate chosen by the top-digit reduction; value equals the
    // candidate index, candidate i holds sum + (i-1)*(2m-1).
    typedef enum logic [1:0] {
        FIX_SUB1 = 2'd0,
        FIX_NONE = 2'd1,
        FIX_ADD1 = 2'd2,
        FIX_ADD2 = 2'd3
    } fix_e;

endpackage

// File: rtl/mrc_csa.sv
module mrc_csa #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);

    logic [W-1:0] maj;

    always_comb begin
        sum_o = a_i ^ b_i ^ c_i;
        maj   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
        cry_o = {maj[W-2:0], 1'b0};
    end

endmodule

// File: rtl/mrc_p_digit.sv
module mrc_p_digit #(
    parameter int M = 21,
    parameter int K = 6
) (
    input  logic [K-1:0] x2_i,
    input  logic [K-1:0] x3_i,
    output logic [K-1:0] p_o,
    output logic         wrap_o
);

    localparam logic [K:0] MOD3 = (K+1)'(2 * M + 1);

    logic [K:0] diff;
    logic [K:0] fixed;

    always_comb begin
        diff   = {1'b0, x2_i} - {1'b0, x3_i};
        wrap_o = diff[K];
        fixed  = diff + (wrap_o ? MOD3 : '0);
        p_o    = fixed[K-1:0];
    end

endmodule

// File: rtl/mrc_qstar.sv
module mrc_qstar
    import mrc_pkg::*;
#(
    parameter int M = 21,
    parameter int K = 6
) (
    input  logic [K-1:0] x1_i,
    input  logic [K-1:0] x2_i,
    input  logic [K-1:0] x3_i,
    input  logic         wrap_i,
    output logic [K-1:0] qs_o
);

    localparam int SW = K + 3;
    localparam int MOD1 = 2 * M - 1;

    logic [SW-1:0] op_x3, op_x1, op_nx2, op_w;
    logic [SW-1:0] s1, c1, s2, c2;
    logic [SW-1:0] total;
    logic [SW-1:0] cand [4];
    logic [3:0]    neg;
    fix_e          pick;

    always_comb begin
        op_x3  = SW'(x3_i);
        op_x1  = SW'(x1_i);
        op_nx2 = ~{2'b00, x2_i, 1'b0};
        op_w   = wrap_i ? {{(SW-1){1'b1}}, 1'b0} : '0;
    end

    mrc_csa #(.W(SW)) i_csa_a (
        .a_i(op_x3), .b_i(op_x1), .c_i(op_nx2),
        .sum_o(s1), .cry_o(c1)
    );

    mrc_csa #(.W(SW)) i_csa_b (
        .a_i(s1), .b_i(c1), .c_i(op_w),
        .sum_o(s2), .cry_o(c2)
    );

    // carry-in of 1 completes the two's complement of 2*x2
    assign total = s2 + c2 + SW'(1);

    for (genvar gi = 0; gi < 4; gi++) begin : g_cand
        localparam logic [SW-1:0] OFS = SW'((gi - 1) * MOD1);
        assign cand[gi] = total + OFS;
        assign neg[gi]  = cand[gi][SW-1];
    end

    always_comb begin
        if (!neg[0])      pick = FIX_SUB1;
        else if (!neg[1]) pick = FIX_NONE;
        else if (!neg[2]) pick = FIX_ADD1;
        else              pick = FIX_ADD2;
    end

    always_comb begin
        unique case (pick)
            FIX_SUB1: qs_o = cand[0][K-1:0];
            FIX_NONE: qs_o = cand[1][K-1:0];
            FIX_ADD1: qs_o = cand[2][K-1:0];
            FIX_ADD2: qs_o = cand[3][K-1:0];
            default:  qs_o = '0;
        endcase
    end

endmodule

// File: rtl/mrc_mul_m.sv
module mrc_mul_m #(
    parameter int M = 21,
    parameter int K = 6
) (
    input  logic [K-1:0] qs_i,
    output logic [K-1:0] q_o
);

    localparam logic [K-1:0] TWO_M = K'(2 * M);

    logic [K-1:0] half;
    logic [K-1:0] gated_m;

    always_comb begin
        half    = {1'b0, qs_i[K-1:1]};
        gated_m = {1'b0, TWO_M[K-1:1]} & {K{qs_i[0]}};
        q_o     = half + gated_m;
    end

endmodule

// File: rtl/mrc_recon.sv
module mrc_recon #(
    parameter int M = 21,
    parameter int K = 6
) (
    input  logic [K-1:0]   x2_i,
    input  logic [K-1:0]   p_i,
    input  logic [K-1:0]   q_i,
    output logic [3*K-1:0] x_o
);

    localparam int XW = 3 * K;
    localparam logic [XW-1:0] W_P = XW'(2 * M);
    localparam logic [XW-1:0] W_Q = XW'(2 * M * (2 * M + 1));

    always_comb begin
        x_o = XW'(x2_i) + XW'(p_i) * W_P + XW'(q_i) * W_Q;
    end

endmodule

// File: rtl/mrc_rns2bin.sv
module mrc_rns2bin #(
    parameter int M = 21,
    localparam int K = $clog2(2 * M + 2)
) (
    input  logic [K-1:0]   res_m1_i,
    input  logic [K-1:0]   res_m2_i,
    input  logic [K-1:0]   res_m3_i,
    output logic [3*K-1:0] value_o,
    output logic [K-1:0]   digit_p_o,
    output logic [K-1:0]   digit_q_o
);

    logic         wrap;
    logic [K-1:0] qstar;

    mrc_p_digit #(.M(M), .K(K)) i_p (
        .x2_i(res_m2_i), .x3_i(res_m3_i),
        .p_o(digit_p_o), .wrap_o(wrap)
    );

    mrc_qstar #(.M(M), .K(K)) i_qs (
        .x1_i(res_m1_i), .x2_i(res_m2_i), .x3_i(res_m3_i),
        .wrap_i(wrap), .qs_o(qstar)
    );

    mrc_mul_m #(.M(M), .K(K)) i_mul (
        .qs_i(qstar), .q_o(digit_q_o)
    );

    mrc_recon #(.M(M), .K(K)) i_rec (
        .x2_i(res_m2_i), .p_i(digit_p_o), .q_i(digit_q_o),
        .x_o(value_o)
    );

endmodule

// File: rtl/mrc_rns2bin_chk.sv
module mrc_rns2bin_chk #(
    parameter int M = 21,
    parameter int K = 6
) (
    input logic [K-1:0]   res_m1_i,
    input logic [K-1:0]   res_m2_i,
    input logic [K-1:0]   res_m3_i,
    input logic [3*K-1:0] value_o,
    input logic [K-1:0]   digit_p_o,
    input logic [K-1:0]   digit_q_o
);

    localparam int MOD1 = 2 * M - 1;
    localparam int MOD2 = 2 * M;
    localparam int MOD3 = 2 * M + 1;
    localparam int RANGE = MOD1 * MOD2 * MOD3;

    logic in_ok;
    int   xv, pv, qv, r1, r2, r3;

    always_comb begin
        r1 = int'(res_m1_i);
        r2 = int'(res_m2_i);
        r3 = int'(res_m3_i);
        xv = int'(value_o);
        pv = int'(digit_p_o);
        qv = int'(digit_q_o);
        in_ok = (r1 < MOD1) && (r2 < MOD2) && (r3 < MOD3);
        if (in_ok) begin
            // R1
            value_range_chk: assert (xv < RANGE);
            // R1
            residues_back_chk: assert ((xv % MOD1 == r1) && (xv % MOD2 == r2) && (xv % MOD3 == r3));
            // R2
            p_digit_range_chk: assert (pv < MOD3);
            // R3
            q_digit_range_chk: assert (qv < MOD1);
            // R4
            p_wrap_chk: assert ((r2 >= r3) ? (pv == r2 - r3) : (pv == r2 - r3 + MOD3));
        end
    end

endmodule

bind mrc_rns2bin mrc_rns2bin_chk #(.M(M), .K(K)) i_chk (
    .res_m1_i(res_m1_i), .res_m2_i(res_m2_i), .res_m3_i(res_m3_i),
    .value_o(value_o), .digit_p_o(digit_p_o), .digit_q_o(digit_q_o)
);

// File: tb/test_mrc_rns2bin.sv
module test_mrc_rns2bin;

    localparam int M = 21;
    localparam int K = $clog2(2 * M + 2);
    localparam int MOD1 = 2 * M - 1;
    localparam int MOD2 = 2 * M;
    localparam int MOD3 = 2 * M + 1;
    localparam int RANGE = MOD1 * MOD2 * MOD3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [K-1:0]   r1, r2, r3;
    logic [3*K-1:0] xo;
    logic [K-1:0]   po, qo;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mrc_rns2bin #(.M(M)) i_mrc_rns2bin (
        .res_m1_i(r1), .res_m2_i(r2), .res_m3_i(r3),
        .value_o(xo), .digit_p_o(po), .digit_q_o(qo)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // apply the residues of integer v, wait one clock, compare
    task automatic apply_value(input int v, input string tag);
        @(negedge clk);
        r1 = K'(v % MOD1);
        r2 = K'(v % MOD2);
        r3 = K'(v % MOD3);
        @(posedge clk);
        #1;
        check(tag, int'(xo), v);
        check(tag, int'(po), (v / MOD2) % MOD3);
        check(tag, int'(qo), v / (MOD2 * MOD3));
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        r1 = '0; r2 = '0; r3 = '0;
        repeat (3) @(posedge clk);
        #1;
        // R7: zero residues during reset give zero outputs
        check("R7", int'(xo), 0);
        check("R7", int'(po), 0);
        check("R7", int'(qo), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: exhaustive sweep of the dynamic range
        for (int v = 0; v < RANGE; v++) begin
            @(negedge clk);
            r1 = K'(v % MOD1);
            r2 = K'(v % MOD2);
            r3 = K'(v % MOD3);
            @(posedge clk);
            #1;
            check("R1", int'(xo), v);
            if (v % MOD2 < v % MOD3)
                check("R4", int'(po), v % MOD2 - v % MOD3 + MOD3);
            else
                check("R2", int'(po), (v / MOD2) % MOD3);
            check("R3", int'(qo), v / (MOD2 * MOD3));
        end

        // R5: equal residues on the diagonal
        for (int r = 0; r < MOD1; r++) begin
            @(negedge clk);
            r1 = K'(r); r2 = K'(r); r3 = K'(r);
            @(posedge clk);
            #1;
            check("R5", int'(xo), r);
            check("R5", int'(po), 0);
            check("R5", int'(qo), 0);
        end

        // R6: top of the range
        @(negedge clk);
        r1 = K'(MOD1 - 1); r2 = K'(MOD2 - 1); r3 = K'(MOD3 - 1);
        @(posedge clk);
        #1;
        check("R6", int'(xo), RANGE - 1);
        check("R6", int'(qo), MOD1 - 1);

        // R8: low extreme x1 = x3 = 0, every x2
        for (int j = 0; j < MOD2; j++)
            apply_value(j * MOD1 * MOD3, "R8");
        // R8: high extreme x1 = 2m-2, x3 = 2m
        for (int j = 1; j <= MOD2; j++)
            apply_value(j * MOD1 * MOD3 - 1, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule